// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the array controller of a word-wide flash. It watches qualified writes, each carrying a 15-bit address and a 16-bit word, and follows the multi-write unlock sequences that guard every state-changing operation. When a sequence completes, it raises a single-cycle start strobe toward the array controller. The strobe carries either the program target or the erase scope. The block does not store array data and does not time any operation. The array controller reports its own activity through `busy_i`.

The block also owns two pieces of mode state. The identification flag changes what `id_rd_data_o` returns for a small set of read addresses. The boot-lock bit can only be set, and it stays set until reset. While it is set, the block keeps program and erase requests away from the low boot region of the array.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Every sequence opens with a write of low byte AA to address 5555h, then a write of low byte 55 to address 2AAAh. Only data bits 7..0 are compared. Bits 15..8 never affect decoding.
- R2: A third write of A0 to 5555h arms a program. The next accepted write, at any address and with any data, causes `prog_go_o` to be high for exactly the one cycle after that write. In that cycle, `op_addr_o` and `op_data_o` hold that write's address and full 16-bit data.
- R3: An erase uses six writes: the R1 pair, then 80 at 5555h, AA at 5555h, 55 at 2AAAh, then a sixth write at 5555h. A sixth write of 10 pulses `erase_go_o` with `erase_boot_o` high while unlocked. A sixth write of 30 pulses `erase_go_o` with `erase_boot_o` low.
- R4: The same six-write form ending in 40 pulses `lock_go_o` for one cycle and sets `boot_lock_o`. After that, `boot_lock_o` stays high until reset.
- R5: While `boot_lock_o` is high, a program aimed at 0000h..1FFFh produces no strobe, and a chip erase (10) reports `erase_boot_o` low. Programs at 2000h and above still start.
- R6: A third write of 90 at 5555h sets `id_mode_o`. A third write of F0 at 5555h clears it.
- R7: Outside an armed program, any accepted write whose low byte is F0 clears `id_mode_o`, whatever its address. A program data word of F0 does not.
- R8: While `id_mode_o` is high, `id_rd_data_o` is 00DAh at read address 0, 00BFh at address 1, and 0000h at every other address. At address 2 it is 00FFh if the lock is set and 00FEh if it is clear. While `id_mode_o` is low, `id_rd_data_o` is 0000h.
- R9: Any write that does not match the expected step returns the decoder to idle and starts nothing. Such a write is not re-read as a new first step.
- R10: Writes presented while `busy_i` is high are ignored. They neither advance nor break a sequence.
- R11: After reset, all strobes, `id_mode_o` and `boot_lock_o` are low. At most one of the three start strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One qualified write this cycle |
| wr_addr_i | input | 15 | Write address |
| wr_data_i | input | 16 | Write data |
| busy_i | input | 1 | Array operation in progress; writes are ignored |
| rd_addr_i | input | 15 | Read address used for the identification data |
| id_rd_data_o | output | 16 | Identification read data |
| id_mode_o | output | 1 | Identification mode active |
| boot_lock_o | output | 1 | Boot region locked |
| prog_go_o | output | 1 | One-cycle program start |
| erase_go_o | output | 1 | One-cycle erase start |
| erase_boot_o | output | 1 | With erase_go_o: the boot region is included |
| lock_go_o | output | 1 | One-cycle lock start |
| op_addr_o | output | 15 | Program target address |
| op_data_o | output | 16 | Program data word |

## Verification
All 256 values of the sixth erase-form write are swept. Each carries an inverted high byte, which separates the three real commands from near misses and shows that the upper byte is ignored. All 256 values of the third write are swept with identification mode already on. This separates entry, exit, program arming, erase arming and breaking writes, and a probe write follows each case to show whether a program was armed. Program addresses from 1FF0h to 200Fh are swept both unlocked and locked to locate the protection edge exactly. Further directed patterns show that a broken prefix is not restarted, that a write under busy is skipped rather than breaking a sequence, and that an F0 program word is not taken as an exit.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_PROG,
    S_ERA3,
    S_ERA4,
    S_ERA5
  } seq_state_e;

  localparam int unsigned CMP_W = 8;

  localparam logic [CMP_W-1:0] K_FIRST    = 8'hAA;
  localparam logic [CMP_W-1:0] K_SECOND   = 8'h55;
  localparam logic [CMP_W-1:0] K_PROG     = 8'hA0;
  localparam logic [CMP_W-1:0] K_ERASE    = 8'h80;
  localparam logic [CMP_W-1:0] K_ID_IN    = 8'h90;
  localparam logic [CMP_W-1:0] K_ID_OUT   = 8'hF0;
  localparam logic [CMP_W-1:0] K_CHIP     = 8'h10;
  localparam logic [CMP_W-1:0] K_MAIN     = 8'h30;
  localparam logic [CMP_W-1:0] K_LOCK     = 8'h40;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int unsigned AW = 15,
  parameter logic [AW-1:0] ADDR_A = 15'h5555,
  parameter logic [AW-1:0] ADDR_B = 15'h2AAA,
  parameter logic [AW-1:0] BOOT_LAST = 15'h1FFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             busy_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CMP_W-1:0] lo_i,
  input  logic             boot_lock_i,
  output logic             dec_prog_o,
  output logic             dec_erase_o,
  output logic             dec_ebt_o,
  output logic             dec_lock_o,
  output logic             id_set_o,
  output logic             id_clr_o
);
  seq_state_e state_q, state_d;
  logic wr_ok, at_a, at_b, is_exit;

  assign wr_ok   = wr_valid_i && !busy_i;
  assign at_a    = (addr_i == ADDR_A);
  assign at_b    = (addr_i == ADDR_B);
  assign is_exit = (lo_i == K_ID_OUT);

  always_comb begin
    state_d     = state_q;
    dec_prog_o  = 1'b0;
    dec_erase_o = 1'b0;
    dec_ebt_o   = 1'b0;
    dec_lock_o  = 1'b0;
    id_set_o    = 1'b0;
    id_clr_o    = 1'b0;
    if (wr_ok) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE: begin
          if (at_a && lo_i == K_FIRST) state_d = S_UNL1;
          else if (is_exit)            id_clr_o = 1'b1;
        end
        S_UNL1: begin
          if (at_b && lo_i == K_SECOND) state_d = S_UNL2;
          else if (is_exit)             id_clr_o = 1'b1;
        end
        S_UNL2: begin
          if (at_a && lo_i == K_PROG)       state_d = S_PROG;
          else if (at_a && lo_i == K_ERASE) state_d = S_ERA3;
          else if (at_a && lo_i == K_ID_IN) id_set_o = 1'b1;
          else if (is_exit)                 id_clr_o = 1'b1;
        end
        S_PROG: begin
          // data word is payload here, never an exit code
          dec_prog_o = !(boot_lock_i && addr_i <= BOOT_LAST);
        end
        S_ERA3: begin
          if (at_a && lo_i == K_FIRST) state_d = S_ERA4;
          else if (is_exit)            id_clr_o = 1'b1;
        end
        S_ERA4: begin
          if (at_b && lo_i == K_SECOND) state_d = S_ERA5;
          else if (is_exit)             id_clr_o = 1'b1;
        end
        S_ERA5: begin
          if (at_a && lo_i == K_CHIP) begin
            dec_erase_o = 1'b1;
            dec_ebt_o   = !boot_lock_i;
          end else if (at_a && lo_i == K_MAIN) begin
            dec_erase_o = 1'b1;
          end else if (at_a && lo_i == K_LOCK) begin
            dec_lock_o = 1'b1;
          end else if (is_exit) begin
            id_clr_o = 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  a_r10_busy_holds_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(state_q));

  a_r9_prog_step_returns_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PROG && wr_valid_i && !busy_i) |=> state_q == S_IDLE);
endmodule

// File: rtl/fcd_mode_regs.sv
module fcd_mode_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic id_set_i,
  input  logic id_clr_i,
  input  logic lock_set_i,
  output logic id_mode_o,
  output logic boot_lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_mode_o   <= 1'b0;
      boot_lock_o <= 1'b0;
    end else begin
      if (id_clr_i)      id_mode_o <= 1'b0;
      else if (id_set_i) id_mode_o <= 1'b1;
      if (lock_set_i)    boot_lock_o <= 1'b1;
    end
  end

  a_r4_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_lock_o |=> boot_lock_o);

  a_r6_id_only_by_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_set_i && !id_clr_i) |=> $stable(id_mode_o));
endmodule

// File: rtl/fcd_out_reg.sv
module fcd_out_reg #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_prog_i,
  input  logic          dec_erase_i,
  input  logic          dec_ebt_i,
  input  logic          dec_lock_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          prog_go_o,
  output logic          erase_go_o,
  output logic          erase_boot_o,
  output logic          lock_go_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_go_o    <= 1'b0;
      erase_go_o   <= 1'b0;
      erase_boot_o <= 1'b0;
      lock_go_o    <= 1'b0;
      op_addr_o    <= '0;
      op_data_o    <= '0;
    end else begin
      prog_go_o    <= dec_prog_i;
      erase_go_o   <= dec_erase_i;
      erase_boot_o <= dec_erase_i && dec_ebt_i;
      lock_go_o    <= dec_lock_i;
      if (dec_prog_i) begin
        op_addr_o <= addr_i;
        op_data_o <= data_i;
      end
    end
  end

  a_r11_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_go_o, erase_go_o, lock_go_o}));

  a_r3_boot_flag_needs_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_boot_o |-> erase_go_o);

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_go_o && !dec_prog_i) |=> !prog_go_o);
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] MFR_CODE = 16'h00DA,
  parameter logic [DW-1:0] DEV_CODE = 16'h00BF,
  parameter logic [DW-1:0] LOCK_ON  = 16'h00FF,
  parameter logic [DW-1:0] LOCK_OFF = 16'h00FE
) (
  input  logic          id_mode_i,
  input  logic          boot_lock_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (id_mode_i) begin
      if (rd_addr_i == AW'(0))      rd_data_o = MFR_CODE;
      else if (rd_addr_i == AW'(1)) rd_data_o = DEV_CODE;
      else if (rd_addr_i == AW'(2)) rd_data_o = boot_lock_i ? LOCK_ON : LOCK_OFF;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] ADDR_A = 15'h5555,
  parameter logic [AW-1:0] ADDR_B = 15'h2AAA,
  parameter logic [AW-1:0] BOOT_LAST = 15'h1FFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          busy_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] id_rd_data_o,
  output logic          id_mode_o,
  output logic          boot_lock_o,
  output logic          prog_go_o,
  output logic          erase_go_o,
  output logic          erase_boot_o,
  output logic          lock_go_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o
);
  logic dec_prog, dec_erase, dec_ebt, dec_lock, id_set, id_clr;

  fcd_seq #(
    .AW(AW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .BOOT_LAST(BOOT_LAST)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .busy_i      (busy_i),
    .addr_i      (wr_addr_i),
    .lo_i        (wr_data_i[CMP_W-1:0]),
    .boot_lock_i (boot_lock_o),
    .dec_prog_o  (dec_prog),
    .dec_erase_o (dec_erase),
    .dec_ebt_o   (dec_ebt),
    .dec_lock_o  (dec_lock),
    .id_set_o    (id_set),
    .id_clr_o    (id_clr)
  );

  fcd_mode_regs u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .id_set_i    (id_set),
    .id_clr_i    (id_clr),
    .lock_set_i  (dec_lock),
    .id_mode_o   (id_mode_o),
    .boot_lock_o (boot_lock_o)
  );

  fcd_out_reg #(.AW(AW), .DW(DW)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dec_prog_i   (dec_prog),
    .dec_erase_i  (dec_erase),
    .dec_ebt_i    (dec_ebt),
    .dec_lock_i   (dec_lock),
    .addr_i       (wr_addr_i),
    .data_i       (wr_data_i),
    .prog_go_o    (prog_go_o),
    .erase_go_o   (erase_go_o),
    .erase_boot_o (erase_boot_o),
    .lock_go_o    (lock_go_o),
    .op_addr_o    (op_addr_o),
    .op_data_o    (op_data_o)
  );

  fcd_id_mux #(.AW(AW), .DW(DW)) u_id (
    .id_mode_i   (id_mode_o),
    .boot_lock_i (boot_lock_o),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (id_rd_data_o)
  );

  a_r5_locked_prog_outside_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_go_o && boot_lock_o) |-> (op_addr_o > BOOT_LAST));

  a_r5_locked_erase_spares_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_go_o && $past(boot_lock_o)) |-> !erase_boot_o);

  a_r10_busy_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(prog_go_o || erase_go_o || lock_go_o));

  a_r8_id_off_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> (id_rd_data_o == '0));
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam logic [14:0] A = 15'h5555;
  localparam logic [14:0] B = 15'h2AAA;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [14:0] wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        busy_i = 1'b0;
  logic [14:0] rd_addr_i = '0;
  logic [15:0] id_rd_data_o;
  logic        id_mode_o, boot_lock_o, prog_go_o, erase_go_o, erase_boot_o, lock_go_o;
  logic [14:0] op_addr_o;
  logic [15:0] op_data_o;

  int total = 0;
  int bad = 0;
  int n_prog = 0, n_erase = 0, n_lock = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .busy_i(busy_i), .rd_addr_i(rd_addr_i),
    .id_rd_data_o(id_rd_data_o), .id_mode_o(id_mode_o), .boot_lock_o(boot_lock_o),
    .prog_go_o(prog_go_o), .erase_go_o(erase_go_o), .erase_boot_o(erase_boot_o),
    .lock_go_o(lock_go_o), .op_addr_o(op_addr_o), .op_data_o(op_data_o)
  );

  always @(negedge clk) begin
    if (prog_go_o)  n_prog++;
    if (erase_go_o) n_erase++;
    if (lock_go_o)  n_lock++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic wr(input logic [14:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid_i = 1'b1;
    wr_addr_i  = a;
    wr_data_i  = d;
    @(negedge clk);
    #1;
    wr_valid_i = 1'b0;
  endtask

  task automatic prefix();
    wr(A, 16'hFFAA);
    wr(B, 16'h0055);
  endtask

  task automatic six(input logic [15:0] d);
    prefix();
    wr(A, 16'h0080);
    wr(A, 16'h00AA);
    wr(B, 16'h0055);
    wr(A, d);
  endtask

  function automatic logic [15:0] id_exp(input int a, input logic lk);
    case (a)
      0: return 16'h00DA;
      1: return 16'h00BF;
      2: return lk ? 16'h00FF : 16'h00FE;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0, e0, l0;
    do_reset();
    // R11 reset state
    chk("R11 reset id_mode", id_mode_o, 0);
    chk("R11 reset boot_lock", boot_lock_o, 0);
    chk("R11 reset strobes", {prog_go_o, erase_go_o, lock_go_o}, 0);
    chk("R8 reset read zero", id_rd_data_o, 0);

    // R1 R3 R4: sweep sixth write, high byte inverted
    for (int d = 0; d < 256; d++) begin
      do_reset();
      p0 = n_prog;
      six({~8'(d), 8'(d)});
      chk("R3 erase strobe", erase_go_o, (d == 16 || d == 48));
      chk("R3 boot included", erase_boot_o, (d == 16));
      chk("R4 lock strobe", lock_go_o, (d == 64));
      chk("R4 lock reg", boot_lock_o, (d == 64));
      chk("R9 no program", n_prog - p0, 0);
    end

    // R6 R2 R9: sweep third write with ID mode already on
    for (int d = 0; d < 256; d++) begin
      do_reset();
      prefix();
      wr(A, 16'h0090);
      p0 = n_prog; e0 = n_erase; l0 = n_lock;
      prefix();
      wr(A, {8'h5A, 8'(d)});
      chk("R6 id after third write", id_mode_o, (d != 8'hF0));
      wr(15'h0100, 16'h1234);
      chk("R2 program strobe", prog_go_o, (d == 8'hA0));
      if (d == 8'hA0) begin
        chk("R2 op addr", op_addr_o, 15'h0100);
        chk("R2 op data", op_data_o, 16'h1234);
      end
      chk("R9 no other op", (n_erase - e0) + (n_lock - l0), 0);
    end

    // R2 one-cycle pulse
    do_reset();
    prefix(); wr(A, 16'h00A0); wr(15'h7FFF, 16'hBEEF);
    chk("R2 pulse high", prog_go_o, 1);
    @(negedge clk); #1;
    chk("R2 pulse one cycle", prog_go_o, 0);

    // R5 boundary sweep, unlocked then locked
    do_reset();
    for (int a = 15'h1FF0; a <= 15'h200F; a++) begin
      prefix(); wr(A, 16'h00A0); wr(15'(a), 16'hC3C3);
      chk("R5 unlocked program", prog_go_o, 1);
    end
    six(16'h0040);
    for (int a = 15'h1FF0; a <= 15'h200F; a++) begin
      prefix(); wr(A, 16'h00A0); wr(15'(a), 16'hC3C3);
      chk("R5 locked program", prog_go_o, (a > 15'h1FFF));
    end
    prefix(); wr(A, 16'h00A0); wr(15'h0000, 16'h0000);
    chk("R5 locked addr 0", prog_go_o, 0);
    six(16'h0010);
    chk("R5 locked chip erase", erase_go_o, 1);
    chk("R5 locked chip erase spares boot", erase_boot_o, 0);
    chk("R4 lock persists", boot_lock_o, 1);
    do_reset();
    chk("R4 lock cleared by reset", boot_lock_o, 0);

    // R8 ID reads, both lock states
    prefix(); wr(A, 16'h0090);
    for (int a = 0; a < 8; a++) begin
      rd_addr_i = 15'(a); #1;
      chk("R8 id read unlocked", id_rd_data_o, id_exp(a, 1'b0));
    end
    six(16'h0040);
    for (int a = 0; a < 8; a++) begin
      rd_addr_i = 15'(a); #1;
      chk("R8 id read locked", id_rd_data_o, id_exp(a, 1'b1));
    end
    rd_addr_i = 15'h4000; #1;
    chk("R8 id read far addr", id_rd_data_o, 0);

    // R7 single-write exit, any address
    wr(15'h1234, 16'hABF0);
    chk("R7 single exit", id_mode_o, 0);
    rd_addr_i = 15'd1; #1;
    chk("R8 read zero when off", id_rd_data_o, 0);

    // R7 F0 as program data does not exit
    do_reset();
    prefix(); wr(A, 16'h0090);
    prefix(); wr(A, 16'h00A0); wr(15'h3000, 16'h00F0);
    chk("R7 program F0 strobe", prog_go_o, 1);
    chk("R7 program F0 keeps id", id_mode_o, 1);

    // R9 broken prefix is not restarted
    do_reset();
    wr(A, 16'h00AA); wr(15'h2AAB, 16'h0055); wr(B, 16'h0055); wr(A, 16'h0090);
    chk("R9 broken prefix", id_mode_o, 0);
    e0 = n_erase;
    prefix(); wr(A, 16'h0080); wr(15'h5554, 16'h00AA); wr(B, 16'h0055); wr(A, 16'h0010);
    chk("R9 broken erase", n_erase - e0, 0);

    // R10 busy writes ignored, sequence kept
    do_reset();
    busy_i = 1'b1;
    prefix(); wr(A, 16'h0090);
    chk("R10 busy no entry", id_mode_o, 0);
    busy_i = 1'b0;
    wr(A, 16'h00AA);
    busy_i = 1'b1;
    wr(15'h0007, 16'h0033);
    busy_i = 1'b0;
    wr(B, 16'h0055); wr(A, 16'h0090);
    chk("R10 busy write skipped", id_mode_o, 1);
    p0 = n_prog;
    prefix(); wr(A, 16'h00A0);
    busy_i = 1'b1;
    wr(15'h4000, 16'h1111);
    chk("R10 busy no program", n_prog - p0, 0);
    busy_i = 1'b0;
    wr(15'h4001, 16'h2222);
    chk("R10 program after busy", op_addr_o, 15'h4001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule